// File: doc/BRIEF.md
# NMI Source Gating Controller

This block holds the system control register and the NMI masking logic of a PC-style platform. Two byte-wide I/O registers sit behind a simple bus made of an address, a write strobe, write data and registered read data.

The control register has two halves. Its upper half is read-only status: a sticky RAM parity flag, a sticky I/O parity flag, the live timer-2 output and a refresh divider bit. Its lower half holds four writable bits: the I/O parity NMI enable, the RAM parity NMI enable, the speaker data enable and the timer-2 gate. The second register holds one global NMI mask bit.

The NMI to the CPU passes through two gates. The per-source enables stop only the parity NMIs, so a coprocessor error still gets through. The global mask stops every source. The timer, speaker, DRAM refresh and parity checkers sit outside this block and connect only through pins.

Top module: `nmi_gate_ctrl`

## Requirements
- R1: After a synchronous reset, every writable bit in both registers is 0, both parity flags are 0 and the refresh divider bit is 0. As a result, `nmi_out`, `spk_data_en` and `tmr2_gate` are 0.
- R2: A read returns data on `bus_rdata` one clock after the address is presented. A control register read (address CTRL_ADDR) returns bit7 = RAM parity flag, bit6 = I/O parity flag, bit5 = timer-2 output, bit4 = refresh divider, and bits 3..0 = the stored writable bits. Write data in bits 7..4 is ignored.
- R3: Control bit 1 drives `spk_data_en` and control bit 0 drives `tmr2_gate`. Each output follows the written value from the clock after the write.
- R4: The RAM parity flag (control bit 7) is set by a one-cycle pulse on `ram_par_err` while the RAM parity enable (control bit 2) is 1. The flag then stays set while that enable stays 1. The flag reads 0 whenever that enable is 0, so a pulse that arrives while the enable is 0 is not recorded.
- R5: The I/O parity flag (control bit 6) follows the same rules as R4, with `io_par_err` as the pulse and control bit 3 as the enable.
- R6: `nmi_out` is a registered version of: NOT mask AND ((RAM flag AND RAM enable) OR (I/O flag AND I/O enable) OR `coproc_err`).
- R7: When both parity enables are 0, an asserted `coproc_err` still drives `nmi_out` to 1, provided the mask is 0.
- R8: Bit 7 of the mask register (address MASK_ADDR) is the global mask. When it is 1, `nmi_out` is 0 for every source. A read of MASK_ADDR returns the mask in bit 7 and 0 in bits 6..0.
- R9: Control bit 5 reads the present level of `tmr2_out`.
- R10: The refresh divider bit (control bit 4) inverts once for each rising edge of `refresh_req`. That input first passes through a SYNC_STAGES-stage synchronizer.
- R11: A read of any other address returns 0x00. A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ram_par_err | input | 1 | RAM parity error pulse |
| io_par_err | input | 1 | I/O parity error pulse |
| coproc_err | input | 1 | Coprocessor error level |
| tmr2_out | input | 1 | Timer channel 2 output |
| refresh_req | input | 1 | Refresh request clock, asynchronous |
| spk_data_en | output | 1 | Speaker data enable |
| tmr2_gate | output | 1 | Timer channel 2 gate |
| nmi_out | output | 1 | NMI request to the CPU |

## Verification
A wrong internal state shows up at the ports in one of two ways. The control register read carries the sticky flags and the stored enables one clock later. `nmi_out` shows a wrong flag, enable or mask two clocks after the pulse or write that caused it. A flag that fails to clear when its enable drops, or a mask that does not block the coprocessor path, therefore shows up within two cycles. A refresh divider that misses or doubles an edge shows up in bit 4 about four cycles after the input edge.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_PAR  = 2;
  // bit positions within the control register
  localparam int B_GATE   = 0;
  localparam int B_SPK    = 1;
  localparam int B_RAM_EN = 2;
  localparam int B_IO_EN  = 3;
  localparam int B_REFR   = 4;
  localparam int B_TMR2   = 5;
  localparam int B_IO_F   = 6;
  localparam int B_RAM_F  = 7;
  localparam int B_MASK   = 7;
  // parity source indices
  localparam int SRC_RAM  = 0;
  localparam int SRC_IO   = 1;
endpackage

// File: rtl/nmi_port_regs.sv
module nmi_port_regs
  import nmi_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h21,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [3:0]        ctrl_bits,
  output logic              mask_bit
);
  logic wr_ctrl, wr_mask;
  assign wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);
  assign wr_mask = bus_wr && (bus_addr == MASK_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_bits <= '0;
      mask_bit  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_bits <= bus_wdata[3:0];
      if (wr_mask) mask_bit  <= bus_wdata[B_MASK];
    end
  end

  assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == CTRL_ADDR) |=> $stable(ctrl_bits));
  assert_mask_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == MASK_ADDR) |=> $stable(mask_bit));
endmodule

// File: rtl/nmi_parity_flag.sv
module nmi_parity_flag (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic err_pulse,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (!enable) flag <= 1'b0;
    else if (err_pulse) flag <= 1'b1;
  end

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (flag && enable) |=> flag);
  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !flag);
endmodule

// File: rtl/nmi_refresh_div.sv
module nmi_refresh_div #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic refresh_req,
  output logic half_rate
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, rise;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= refresh_req;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign rise = sync_q[SYNC_STAGES-1] && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= 1'b0;
      half_rate <= 1'b0;
    end else begin
      prev_q    <= sync_q[SYNC_STAGES-1];
      if (rise) half_rate <= !half_rate;
    end
  end

  assert_toggle_on_edge_R10: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(half_rate));
endmodule

// File: rtl/nmi_combiner.sv
module nmi_combiner
  import nmi_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_PAR-1:0] par_flag,
  input  logic [NUM_PAR-1:0] par_en,
  input  logic               coproc_err,
  input  logic               mask,
  output logic               nmi_out
);
  logic any_src;
  assign any_src = (|(par_flag & par_en)) || coproc_err;

  always_ff @(posedge clk) begin
    if (rst) nmi_out <= 1'b0;
    else     nmi_out <= !mask && any_src;
  end

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    mask |=> !nmi_out);
  assert_coproc_passes_R7: assert property (@(posedge clk) disable iff (rst)
    (coproc_err && !mask) |=> nmi_out);
endmodule

// File: rtl/nmi_gate_ctrl.sv
module nmi_gate_ctrl
  import nmi_gate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h21,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h22,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ram_par_err,
  input  logic              io_par_err,
  input  logic              coproc_err,
  input  logic              tmr2_out,
  input  logic              refresh_req,
  output logic              spk_data_en,
  output logic              tmr2_gate,
  output logic              nmi_out
);
  logic [3:0]         ctrl_bits;
  logic               mask_bit;
  logic               half_rate;
  logic [NUM_PAR-1:0] par_en, par_err, par_flag;
  logic [7:0]         rd_mux;

  nmi_port_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MASK_ADDR(MASK_ADDR)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .ctrl_bits(ctrl_bits), .mask_bit(mask_bit));

  assign par_en[SRC_RAM]  = ctrl_bits[B_RAM_EN];
  assign par_en[SRC_IO]   = ctrl_bits[B_IO_EN];
  assign par_err[SRC_RAM] = ram_par_err;
  assign par_err[SRC_IO]  = io_par_err;

  generate
    for (genvar s = 0; s < NUM_PAR; s++) begin : g_par
      nmi_parity_flag u_flag (
        .clk(clk), .rst(rst), .enable(par_en[s]),
        .err_pulse(par_err[s]), .flag(par_flag[s]));
    end
  endgenerate

  nmi_refresh_div #(.SYNC_STAGES(SYNC_STAGES)) u_refr (
    .clk(clk), .rst(rst), .refresh_req(refresh_req), .half_rate(half_rate));

  nmi_combiner u_comb (
    .clk(clk), .rst(rst), .par_flag(par_flag), .par_en(par_en),
    .coproc_err(coproc_err), .mask(mask_bit), .nmi_out(nmi_out));

  assign spk_data_en = ctrl_bits[B_SPK];
  assign tmr2_gate   = ctrl_bits[B_GATE];

  always_comb begin
    rd_mux = '0;
    if (bus_addr == CTRL_ADDR) begin
      rd_mux[3:0]     = ctrl_bits;
      rd_mux[B_REFR]  = half_rate;
      rd_mux[B_TMR2]  = tmr2_out;
      rd_mux[B_IO_F]  = par_flag[SRC_IO];
      rd_mux[B_RAM_F] = par_flag[SRC_RAM];
    end else if (bus_addr == MASK_ADDR) begin
      rd_mux[B_MASK]  = mask_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != CTRL_ADDR && bus_addr != MASK_ADDR) |=> bus_rdata == 8'h00);
  assert_mask_low_bits_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == MASK_ADDR) |=> bus_rdata[6:0] == 7'd0);
endmodule

// File: tb/sim_nmi_gate_ctrl.sv
module sim_nmi_gate_ctrl;
  localparam logic [7:0] CA = 8'h21, MA = 8'h22, UA = 8'h30;
  logic clk = 0, rst = 1;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_wr = 0, ram_par_err = 0, io_par_err = 0, coproc_err = 0;
  logic tmr2_out = 0, refresh_req = 0, spk_data_en, tmr2_gate, nmi_out;
  int checks = 0, failures = 0;
  bit done = 0;
  // bench model
  logic [3:0] m_ctrl = 0;
  logic m_mask = 0, m_ramf = 0, m_iof = 0, m_tog = 0;

  always #4 clk = ~clk;

  nmi_gate_ctrl u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ram_par_err(ram_par_err),
    .io_par_err(io_par_err), .coproc_err(coproc_err), .tmr2_out(tmr2_out),
    .refresh_req(refresh_req), .spk_data_en(spk_data_en), .tmr2_gate(tmr2_gate),
    .nmi_out(nmi_out));

  function automatic logic [7:0] exp_ctrl();
    return {m_ramf, m_iof, tmr2_out, m_tog, m_ctrl};
  endfunction
  function automatic logic exp_nmi();
    return !m_mask && ((m_ramf && m_ctrl[2]) || (m_iof && m_ctrl[3]) || coproc_err);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
    if (a == CA) begin
      m_ctrl = d[3:0];
      if (!m_ctrl[2]) m_ramf = 0;
      if (!m_ctrl[3]) m_iof = 0;
    end else if (a == MA) m_mask = d[7];
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic pulse(input bit ram);
    @(negedge clk);
    if (ram) ram_par_err = 1; else io_par_err = 1;
    @(negedge clk); ram_par_err = 0; io_par_err = 0;
    if (ram) m_ramf = m_ramf | m_ctrl[2]; else m_iof = m_iof | m_ctrl[3];
  endtask

  task automatic refr_level(input logic v);
    @(negedge clk);
    if (v && !refresh_req) m_tog = !m_tog;
    refresh_req = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk({req, " nmi_out R6"}, {7'd0, nmi_out}, {7'd0, exp_nmi()});
    rd(CA, d);
    chk({req, " ctrl read R2"}, d, exp_ctrl());
    chk({req, " spk/gate R3"}, {6'd0, spk_data_en, tmr2_gate}, {6'd0, m_ctrl[1:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(CA, d); chk("R1 ctrl after reset", d, 8'h00);
    rd(MA, d); chk("R1 mask after reset", d, 8'h00);
    chk("R1 outputs after reset", {5'd0, nmi_out, spk_data_en, tmr2_gate}, 8'h00);
    // R2 upper write ignored
    wr(CA, 8'hF3); check_all("R2 upper ignored");
    // R9 timer2 live
    @(negedge clk); tmr2_out = 1; rd(CA, d); chk("R9 timer2 bit", d, exp_ctrl());
    // R4 pulse ignored while disabled
    pulse(1); rd(CA, d); chk("R4 disabled pulse", d[7:0], exp_ctrl());
    // R4 enable and latch
    wr(CA, 8'h04); pulse(1); check_all("R4 latch");
    chk("R4 flag set", {7'd0, m_ramf}, 8'h01);
    repeat (10) @(negedge clk); rd(CA, d); chk("R4 sticky", d, exp_ctrl());
    wr(CA, 8'h00); check_all("R4 clear on disable");
    // R5 io
    wr(CA, 8'h08); pulse(0); check_all("R5 io latch");
    chk("R5 nmi", {7'd0, nmi_out}, 8'h01);
    // R8 mask blocks parity
    wr(MA, 8'h80); check_all("R8 mask parity");
    rd(MA, d); chk("R8 mask read", d, 8'h80);
    // R7 coproc passes with enables off, R8 blocks it
    wr(CA, 8'h00); @(negedge clk); coproc_err = 1; check_all("R7/R8 masked coproc");
    wr(MA, 8'h7F); check_all("R7 coproc passes");
    chk("R7 nmi high", {7'd0, nmi_out}, 8'h01);
    @(negedge clk); coproc_err = 0;
    // R11 unmapped
    wr(UA, 8'hFF); check_all("R11 unmapped write");
    rd(MA, d); chk("R11 mask unchanged", d, 8'h00);
    rd(UA, d); chk("R11 unmapped read", d, 8'h00);
    // R10 refresh edges
    for (int i = 0; i < 5; i++) begin
      refr_level(1); refr_level(0);
    end
    check_all("R10 refresh toggles");
    // random mix
    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 6))
        0: wr(CA, 8'($urandom));
        1: wr(MA, 8'($urandom));
        2: pulse(1);
        3: pulse(0);
        4: begin @(negedge clk); coproc_err = $urandom_range(0, 1); end
        5: begin @(negedge clk); tmr2_out = $urandom_range(0, 1); end
        default: refr_level(!refresh_req);
      endcase
      check_all("rand R6");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule